// File: doc/BRIEF.md
# VGA 640x480 Raster Timing Generator

This block produces the scan timing for a 640 by 480 display refreshed at about 60 Hz from a 25 MHz pixel clock. A column counter advances on every clock over an 800-clock line. A row counter advances once per line over a 521-line frame. From these two counts the block derives active-low horizontal and vertical sync, a display-enable flag, a one-cycle start-of-frame marker and a linear video-memory address.

The surrounding logic supplies one 8-bit pixel per clock, packed as red, green and blue. The block gates that pixel onto its colour outputs only inside the visible window and holds them at zero during porches and sync. Column, row, sync, enable, address and colour all refer to the same clock cycle, so a caller can use the address to fetch pixel data from a combinational source and get correct alignment.

Top module: `vga_timing_gen`

## Requirements
- R1: `col_o` is 0 after reset, increases by one on every clock, and wraps from 799 to 0.
- R2: `row_o` is 0 after reset, changes only in the clock after `col_o` is 799, increases by one there, and wraps from 520 to 0.
- R3: `hsync_no` is low exactly while `col_o` is in 656..751 and high for every other column.
- R4: `vsync_no` is low exactly while `row_o` is 490 or 491 and high for every other row.
- R5: `de_o` is high exactly when `col_o` < 640 and `row_o` < 480.
- R6: while `de_o` is high, `red_o` equals `pix_i[7:5]`, `green_o` equals `pix_i[4:2]` and `blue_o` equals `pix_i[1:0]` in the same cycle. While `de_o` is low, all three are zero regardless of `pix_i`.
- R7: `sof_o` is high exactly in the cycles where `col_o` and `row_o` are both 0.
- R8: `addr_o` equals `row_o`*640 + `col_o` while `de_o` is high and is zero otherwise.
- R9: asserting `rst_ni` low at any point in the frame returns column and row to 0 at once and holds them there until release. Counting then resumes from the top-left pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | pixel clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| pix_i | input | 8 | pixel from user source: red [7:5], green [4:2], blue [1:0] |
| col_o | output | 10 | current column, 0..799 |
| row_o | output | 10 | current row, 0..520 |
| hsync_no | output | 1 | horizontal sync, active low |
| vsync_no | output | 1 | vertical sync, active low |
| de_o | output | 1 | visible-area enable |
| sof_o | output | 1 | start-of-frame marker |
| addr_o | output | 19 | video memory address, zero while blanked |
| red_o | output | 3 | red level |
| green_o | output | 3 | green level |
| blue_o | output | 2 | blue level |

## Verification
Vertical sync and the wrap of both the row counter and the address occur only after nearly 400,000 clocks at full geometry. A second instance built with a shrunken geometry (25-clock lines, 13-line frames) reaches them, and the bench runs several whole frames of it, including a reset taken in mid-frame. The full-size instance runs alongside for more than a hundred lines, which checks the real horizontal timing and the address arithmetic across many row boundaries. The pixel input changes on every clock, so blanking and channel mapping are checked against values that keep varying.

// File: rtl/vga_timing_pkg.sv
`timescale 1ns/1ps
package vga_timing_pkg;
  localparam int unsigned RED_W = 3;
  localparam int unsigned GRN_W = 3;
  localparam int unsigned BLU_W = 2;
  localparam int unsigned PIX_W = RED_W + GRN_W + BLU_W;

  typedef struct packed {
    logic [RED_W-1:0] r;
    logic [GRN_W-1:0] g;
    logic [BLU_W-1:0] b;
  } rgb_t;
endpackage

// File: rtl/vga_axis_counter.sv
`timescale 1ns/1ps
module vga_axis_counter #(
  parameter int unsigned VIS  = 640,
  parameter int unsigned FP   = 16,
  parameter int unsigned SYNC = 96,
  parameter int unsigned BP   = 48,
  localparam int unsigned TOTAL = VIS + FP + SYNC + BP,
  localparam int unsigned W     = $clog2(TOTAL)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  output logic [W-1:0] cnt_o,
  output logic         first_o,
  output logic         last_o,
  output logic         vis_o,
  output logic         sync_o
);
  localparam logic [W-1:0] LAST    = W'(TOTAL - 1);
  localparam logic [W-1:0] VIS_END = W'(VIS);
  localparam logic [W-1:0] SYNC_LO = W'(VIS + FP);
  localparam logic [W-1:0] SYNC_HI = W'(VIS + FP + SYNC);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (step_i) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  assign cnt_o   = cnt_q;
  assign first_o = (cnt_q == '0);
  assign last_o  = (cnt_q == LAST);
  assign vis_o   = (cnt_q < VIS_END);
  assign sync_o  = (cnt_q >= SYNC_LO) && (cnt_q < SYNC_HI);
endmodule

// File: rtl/vga_addr_gen.sv
`timescale 1ns/1ps
// Running address: advances after each visible pixel, cleared at frame end.
module vga_addr_gen #(
  parameter int unsigned AW = 19
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          de_i,
  input  logic          frame_end_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          addr_q <= '0;
    else if (frame_end_i) addr_q <= '0;
    else if (de_i)        addr_q <= addr_q + 1'b1;
  end

  assign addr_o = de_i ? addr_q : '0;
endmodule

// File: rtl/vga_pixel_gate.sv
`timescale 1ns/1ps
module vga_pixel_gate
  import vga_timing_pkg::*;
(
  input  logic de_i,
  input  rgb_t pix_i,
  output rgb_t pix_o
);
  always_comb begin
    pix_o = '0;
    if (de_i) pix_o = pix_i;
  end
endmodule

// File: rtl/vga_timing_gen.sv
`timescale 1ns/1ps
module vga_timing_gen
  import vga_timing_pkg::*;
#(
  parameter int unsigned H_VIS  = 640,
  parameter int unsigned H_FP   = 16,
  parameter int unsigned H_SYNC = 96,
  parameter int unsigned H_BP   = 48,
  parameter int unsigned V_VIS  = 480,
  parameter int unsigned V_FP   = 10,
  parameter int unsigned V_SYNC = 2,
  parameter int unsigned V_BP   = 29,
  localparam int unsigned H_TOTAL = H_VIS + H_FP + H_SYNC + H_BP,
  localparam int unsigned V_TOTAL = V_VIS + V_FP + V_SYNC + V_BP,
  localparam int unsigned CW = $clog2(H_TOTAL),
  localparam int unsigned RW = $clog2(V_TOTAL),
  localparam int unsigned AW = $clog2(H_VIS * V_VIS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PIX_W-1:0]  pix_i,
  output logic [CW-1:0]     col_o,
  output logic [RW-1:0]     row_o,
  output logic              hsync_no,
  output logic              vsync_no,
  output logic              de_o,
  output logic              sof_o,
  output logic [AW-1:0]     addr_o,
  output logic [RED_W-1:0]  red_o,
  output logic [GRN_W-1:0]  green_o,
  output logic [BLU_W-1:0]  blue_o
);
  logic h_first, h_last, h_vis, h_sync;
  logic v_first, v_last, v_vis, v_sync;
  logic de;
  rgb_t pix_gated;

  vga_axis_counter #(
    .VIS(H_VIS), .FP(H_FP), .SYNC(H_SYNC), .BP(H_BP)
  ) u_hcnt (
    .clk_i, .rst_ni,
    .step_i  (1'b1),
    .cnt_o   (col_o),
    .first_o (h_first),
    .last_o  (h_last),
    .vis_o   (h_vis),
    .sync_o  (h_sync)
  );

  vga_axis_counter #(
    .VIS(V_VIS), .FP(V_FP), .SYNC(V_SYNC), .BP(V_BP)
  ) u_vcnt (
    .clk_i, .rst_ni,
    .step_i  (h_last),
    .cnt_o   (row_o),
    .first_o (v_first),
    .last_o  (v_last),
    .vis_o   (v_vis),
    .sync_o  (v_sync)
  );

  assign de       = h_vis & v_vis;
  assign de_o     = de;
  assign hsync_no = ~h_sync;
  assign vsync_no = ~v_sync;
  assign sof_o    = h_first & v_first;

  vga_addr_gen #(.AW(AW)) u_addr (
    .clk_i, .rst_ni,
    .de_i        (de),
    .frame_end_i (h_last & v_last),
    .addr_o      (addr_o)
  );

  vga_pixel_gate u_gate (
    .de_i  (de),
    .pix_i (rgb_t'(pix_i)),
    .pix_o (pix_gated)
  );

  assign red_o   = pix_gated.r;
  assign green_o = pix_gated.g;
  assign blue_o  = pix_gated.b;
endmodule

// File: rtl/vga_timing_checker.sv
`timescale 1ns/1ps
module vga_timing_checker #(
  parameter int unsigned H_VIS  = 640,
  parameter int unsigned H_FP   = 16,
  parameter int unsigned H_SYNC = 96,
  parameter int unsigned H_BP   = 48,
  parameter int unsigned V_VIS  = 480,
  parameter int unsigned V_FP   = 10,
  parameter int unsigned V_SYNC = 2,
  parameter int unsigned V_BP   = 29,
  parameter int unsigned CW = 10,
  parameter int unsigned RW = 10,
  parameter int unsigned AW = 19
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [CW-1:0] col_o,
  input logic [RW-1:0] row_o,
  input logic          hsync_no,
  input logic          vsync_no,
  input logic          de_o,
  input logic          sof_o,
  input logic [AW-1:0] addr_o,
  input logic [2:0]    red_o,
  input logic [2:0]    green_o,
  input logic [1:0]    blue_o
);
  localparam int unsigned H_LAST = H_VIS + H_FP + H_SYNC + H_BP - 1;
  localparam int unsigned V_LAST = V_VIS + V_FP + V_SYNC + V_BP - 1;

  p_col_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(col_o) != H_LAST) |=> (32'(col_o) == 32'($past(col_o)) + 1));
  p_col_wrap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(col_o) == H_LAST) |=> (col_o == '0));
  p_row_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(col_o) != H_LAST) |=> $stable(row_o));
  p_row_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(col_o) == H_LAST && 32'(row_o) == V_LAST) |=> (row_o == '0));
  p_hs_fall_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hsync_no) |-> (32'(col_o) == H_VIS + H_FP));
  p_vs_rise_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vsync_no) |-> (32'(row_o) == V_VIS + V_FP + V_SYNC));
  p_blank_rgb_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !de_o |-> (red_o == '0 && green_o == '0 && blue_o == '0));
  p_sof_origin_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_o |-> (de_o && addr_o == '0));
  p_addr_step_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (de_o && 32'(col_o) != H_VIS - 1) |=> (32'(addr_o) == 32'($past(addr_o)) + 1));
endmodule

bind vga_timing_gen vga_timing_checker #(
  .H_VIS(H_VIS), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
  .V_VIS(V_VIS), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP),
  .CW(CW), .RW(RW), .AW(AW)
) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .col_o(col_o), .row_o(row_o),
  .hsync_no(hsync_no), .vsync_no(vsync_no), .de_o(de_o), .sof_o(sof_o),
  .addr_o(addr_o), .red_o(red_o), .green_o(green_o), .blue_o(blue_o)
);

// File: tb/test_vga_timing_gen.sv
`timescale 1ns/1ps
module test_vga_timing_gen;
  localparam int NCYC = 100000;
  // shrunken geometry reaching vsync and frame wrap within the run
  localparam int S_HV = 16, S_HF = 2, S_HS = 3, S_HB = 4;
  localparam int S_VV = 6,  S_VF = 2, S_VS = 2, S_VB = 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [7:0] pix = 8'h00;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  logic [9:0] f_col, f_row; logic [18:0] f_addr;
  logic f_hs, f_vs, f_de, f_sof; logic [2:0] f_r, f_g; logic [1:0] f_b;
  logic [4:0] s_col; logic [3:0] s_row; logic [6:0] s_addr;
  logic s_hs, s_vs, s_de, s_sof; logic [2:0] s_r, s_g; logic [1:0] s_b;

  vga_timing_gen i_vga_timing_gen (
    .clk_i(clk), .rst_ni(rst_ni), .pix_i(pix),
    .col_o(f_col), .row_o(f_row), .hsync_no(f_hs), .vsync_no(f_vs),
    .de_o(f_de), .sof_o(f_sof), .addr_o(f_addr),
    .red_o(f_r), .green_o(f_g), .blue_o(f_b));

  vga_timing_gen #(
    .H_VIS(S_HV), .H_FP(S_HF), .H_SYNC(S_HS), .H_BP(S_HB),
    .V_VIS(S_VV), .V_FP(S_VF), .V_SYNC(S_VS), .V_BP(S_VB)
  ) i_vga_timing_gen_small (
    .clk_i(clk), .rst_ni(rst_ni), .pix_i(pix),
    .col_o(s_col), .row_o(s_row), .hsync_no(s_hs), .vsync_no(s_vs),
    .de_o(s_de), .sof_o(s_sof), .addr_o(s_addr),
    .red_o(s_r), .green_o(s_g), .blue_o(s_b));

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      if (n_fail <= 20)
        $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic check_all(string who, int h, int v,
      int hv, int hf, int hs, int vv, int vf, int vs,
      logic [31:0] col, logic [31:0] row, logic hsn, logic vsn, logic de,
      logic sof, logic [31:0] addr, logic [7:0] rgb);
    bit ede = (h < hv) && (v < vv);
    check("R1", {who, " col"}, col, h);
    check("R2", {who, " row"}, row, v);
    check("R3", {who, " hsync"}, 32'(hsn), 32'(!(h >= hv + hf && h < hv + hf + hs)));
    check("R4", {who, " vsync"}, 32'(vsn), 32'(!(v >= vv + vf && v < vv + vf + vs)));
    check("R5", {who, " de"}, 32'(de), 32'(ede));
    check("R6", {who, " rgb"}, 32'(rgb), ede ? 32'(pix) : 32'd0);
    check("R7", {who, " sof"}, 32'(sof), 32'(h == 0 && v == 0));
    check("R8", {who, " addr"}, addr, ede ? 32'(v * hv + h) : 32'd0);
  endtask

  initial begin
    int fh = 0, fv = 0, sh = 0, sv = 0;
    @(negedge clk); @(negedge clk);
    // R9: reset state
    check_all("full", 0, 0, 640, 16, 96, 480, 10, 2,
      32'(f_col), 32'(f_row), f_hs, f_vs, f_de, f_sof, 32'(f_addr), {f_r, f_g, f_b});
    check("R9", "small col in reset", 32'(s_col), 0);
    rst_ni = 1'b1;
    for (int c = 0; c < NCYC; c++) begin
      @(posedge clk);
      if (!rst_ni) begin
        fh = 0; fv = 0; sh = 0; sv = 0;
      end else begin
        fh++; if (fh == 800) begin fh = 0; fv = (fv == 520) ? 0 : fv + 1; end
        sh++; if (sh == 25) begin sh = 0; sv = (sv == 12) ? 0 : sv + 1; end
      end
      #2 pix = 8'(c * 37 + 11);
      @(negedge clk);
      check_all("full", fh, fv, 640, 16, 96, 480, 10, 2,
        32'(f_col), 32'(f_row), f_hs, f_vs, f_de, f_sof, 32'(f_addr), {f_r, f_g, f_b});
      if (c < 2000)
        check_all("small", sh, sv, S_HV, S_HF, S_HS, S_VV, S_VF, S_VS,
          32'(s_col), 32'(s_row), s_hs, s_vs, s_de, s_sof, 32'(s_addr), {s_r, s_g, s_b});
      // R9: mid-frame reset, then resume from top-left
      if (c == 700) rst_ni = 1'b0;
      if (c == 702) begin
        check("R9", "full col held in reset", 32'(f_col), 0);
        check("R9", "small row held in reset", 32'(s_row), 0);
        rst_ni = 1'b1;
      end
    end
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(64'd20 * 64'd190000);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule